// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block raises an interrupt after a programmed number of video scanlines. A cartridge mapper feeds it one pulse per scanline: a single-cycle pulse that marks a filtered rising edge of video address line 12. An 8-bit down counter counts these pulses. When the counter comes back to zero while interrupts are enabled, the block raises a level interrupt request to the CPU. The request stays high until software acknowledges it.

The CPU reaches four write-only registers through a decoded 2-bit select, a strobe and a data byte. The registers hold the reload value, clear the counter, disable and acknowledge the interrupt, and enable the interrupt. A mode input selects an alternate counter rule. Under that rule a counter clear leaves a pending-clear flag set, and an interrupt needs either a nonzero count before the pulse or a pending clear.

The counter's action on each cycle is picked from four named steps. HOLD applies when there is no pulse and no clear. ZERO applies on a clear write. RELOAD applies on a pulse when the count is zero or a clear is pending. DECR applies on any other pulse. The interrupt line is a two-state machine. It moves from LINE_IDLE to LINE_RAISED on a fire, and back from LINE_RAISED to LINE_IDLE on an acknowledge. In every other case it stays in its current state.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset the interrupt output is low, the reload value is 0xFF, the counter is 0, interrupts are disabled and no clear is pending. With interrupts then enabled, the first interrupt comes on the 256th line pulse.
- R2: A write with select 0 stores the data byte as the reload value. The new value is used at the next reload.
- R3: A write with select 1 sets the counter to 0. If the mode input is high at that write, it also sets the pending-clear flag.
- R4: On a line pulse the counter loads the reload value if it is 0 or a clear is pending. Otherwise it decrements by one.
- R5: In the standard mode (mode input low), a pulse that leaves the counter at 0 while interrupts are enabled raises the interrupt.
- R6: In the alternate mode (mode input high), the interrupt also needs the pre-pulse count to be nonzero or a clear to be pending.
- R7: Every line pulse that is processed drops the pending-clear flag.
- R8: A write with select 2 disables interrupts and drops the interrupt output on the next cycle. A write with select 3 enables interrupts and leaves the output unchanged.
- R9: Once raised, the interrupt output stays high until a select-2 write or a reset.
- R10: A line pulse in the same cycle as a select-1 write is ignored. The counter ends at 0 and the pending-clear flag is not consumed.
- R11: A pulse that coincides with a select 0, 2 or 3 write uses the register values from before the write. A select-2 write wins over a fire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | CPU register write strobe |
| wr_sel | input | 2 | Register select: 0 reload, 1 clear, 2 disable/ack, 3 enable |
| wr_data | input | 8 | Write data byte |
| line_pulse | input | 1 | One-cycle pulse per filtered A12 rising edge |
| alt_mode | input | 1 | High selects the alternate counter rule |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench sweeps reload values 0 to 31 in both modes and checks the interrupt cycle by cycle against an arithmetic model. A counter off by one in its reload or decrement would fire one line early or late. Reload value 0 is the sharpest case. The standard mode must fire on every pulse, while the alternate mode must fire only on the pulse that consumes a pending clear. A design that failed to drop the pending flag would keep firing. Directed runs cover the 256-pulse count from reset and a clear that collides with a pulse (a design that let the pulse through would reload early). They also cover an acknowledge that collides with a fire, and an enable write that must not clear a raised line. A long pseudo-random mix of writes and pulses then checks every cycle in both modes.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
    typedef enum logic [1:0] {
        SEL_RELOAD  = 2'd0,
        SEL_CLEAR   = 2'd1,
        SEL_DISABLE = 2'd2,
        SEL_ENABLE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_ZERO,
        STEP_RELOAD,
        STEP_DECR
    } step_e;

    typedef enum logic {
        LINE_IDLE,
        LINE_RAISED
    } line_e;
endpackage

// File: rtl/scl_ctrl_regs.sv
module scl_ctrl_regs
    import scanline_irq_pkg::*;
#(
    parameter int          CNT_W       = 8,
    parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             alt_mode,
    input  logic             edge_taken,
    output logic [CNT_W-1:0] reload_val,
    output logic             irq_en,
    output logic             clr_pend,
    output logic             clr_write,
    output logic             ack_write
);
    reg_sel_e sel;
    logic     load_write;
    logic     en_write;

    assign sel        = reg_sel_e'(wr_sel);
    assign load_write = wr_en && (sel == SEL_RELOAD);
    assign clr_write  = wr_en && (sel == SEL_CLEAR);
    assign ack_write  = wr_en && (sel == SEL_DISABLE);
    assign en_write   = wr_en && (sel == SEL_ENABLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_val <= RELOAD_INIT;
            irq_en     <= 1'b0;
            clr_pend   <= 1'b0;
        end else begin
            if (load_write)
                reload_val <= wr_data;
            if (ack_write)
                irq_en <= 1'b0;
            else if (en_write)
                irq_en <= 1'b1;
            if (clr_write && alt_mode)
                clr_pend <= 1'b1;
            else if (edge_taken)
                clr_pend <= 1'b0;
        end
    end

    // R3
    clr_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_write && alt_mode) |=> clr_pend);

    // R7
    clr_flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_taken |=> !clr_pend);

    // R8
    enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> irq_en);
endmodule

// File: rtl/scl_down_counter.sv
module scl_down_counter
    import scanline_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_pulse,
    input  logic             clr_write,
    input  logic             clr_pend,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             irq_en,
    input  logic             alt_mode,
    output logic             edge_taken,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    step_e            step;
    logic             gate_ok;

    always_comb begin
        if (clr_write)
            step = STEP_ZERO;
        else if (line_pulse && (cnt == ZERO || clr_pend))
            step = STEP_RELOAD;
        else if (line_pulse)
            step = STEP_DECR;
        else
            step = STEP_HOLD;
    end

    always_comb begin
        unique case (step)
            STEP_HOLD:   cnt_next = cnt;
            STEP_ZERO:   cnt_next = ZERO;
            STEP_RELOAD: cnt_next = reload_val;
            STEP_DECR:   cnt_next = cnt - ONE;
            default:     cnt_next = cnt;
        endcase
    end

    assign edge_taken = (step == STEP_RELOAD) || (step == STEP_DECR);
    assign gate_ok    = !alt_mode || (cnt != ZERO) || clr_pend;
    assign fire       = edge_taken && (cnt_next == ZERO) && irq_en && gate_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= ZERO;
        else
            cnt <= cnt_next;
    end

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_write |=> (cnt == ZERO));

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_write && line_pulse) |-> !edge_taken);

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pulse && !clr_write && (cnt == ZERO || clr_pend)) |=> (cnt == $past(reload_val)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_pulse && !clr_write) |=> $stable(cnt));

    // R6
    alt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_mode && line_pulse && cnt == ZERO && !clr_pend) |-> !fire);
endmodule

// File: rtl/scl_irq_line.sv
module scl_irq_line
    import scanline_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic ack,
    output logic irq
);
    line_e state;
    line_e state_next;

    always_comb begin
        unique case (state)
            LINE_IDLE:   state_next = (fire && !ack) ? LINE_RAISED : LINE_IDLE;
            LINE_RAISED: state_next = ack ? LINE_IDLE : LINE_RAISED;
            default:     state_next = LINE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= LINE_IDLE;
        else
            state <= state_next;
    end

    always_comb begin
        irq = (state == LINE_RAISED);
    end

    // R8
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !irq);

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);

    // R5
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(fire));
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
    import scanline_irq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             line_pulse,
    input  logic             alt_mode,
    output logic             irq
);
    logic [CNT_W-1:0] reload_val;
    logic             irq_en;
    logic             clr_pend;
    logic             clr_write;
    logic             ack_write;
    logic             edge_taken;
    logic             fire;

    scl_ctrl_regs #(.CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .alt_mode   (alt_mode),
        .edge_taken (edge_taken),
        .reload_val (reload_val),
        .irq_en     (irq_en),
        .clr_pend   (clr_pend),
        .clr_write  (clr_write),
        .ack_write  (ack_write)
    );

    scl_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_pulse (line_pulse),
        .clr_write  (clr_write),
        .clr_pend   (clr_pend),
        .reload_val (reload_val),
        .irq_en     (irq_en),
        .alt_mode   (alt_mode),
        .edge_taken (edge_taken),
        .fire       (fire)
    );

    scl_irq_line u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .ack   (ack_write),
        .irq   (irq)
    );

    // R11
    ack_beats_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && ack_write) |=> !irq);
endmodule

// File: tb/tb_scanline_irq_counter.sv
module tb_scanline_irq_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       line_pulse = 1'b0;
    logic       alt_mode = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int m_cnt, m_rel, m_en, m_clr, m_irq;

    scanline_irq_counter dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .line_pulse(line_pulse), .alt_mode(alt_mode), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: irq actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit w, input logic [1:0] s, input logic [7:0] d,
                       input bit e, input string tag);
        int  old;
        bit  fire;
        wr_en = w; wr_sel = s; wr_data = d; line_pulse = e;
        @(posedge clk);
        fire = 1'b0;
        if (w && s == 2'd1) begin
            m_cnt = 0;
            if (alt_mode) m_clr = 1;
        end else if (e) begin
            old   = m_cnt;
            m_cnt = (old == 0 || m_clr == 1) ? m_rel : old - 1;
            fire  = (m_cnt == 0) && (m_en == 1) && (!alt_mode || old != 0 || m_clr == 1);
            m_clr = 0;
        end
        if (w && s == 2'd0) m_rel = d;
        if (w && s == 2'd2) begin m_en = 0; m_irq = 0; end
        else if (fire) m_irq = 1;
        if (w && s == 2'd3) m_en = 1;
        @(negedge clk);
        wr_en = 1'b0; line_pulse = 1'b0;
        check(tag, int'(irq), m_irq);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; line_pulse = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0; m_rel = 255; m_en = 0; m_clr = 0; m_irq = 0;
        @(negedge clk);
        check("R1 reset", int'(irq), 0);
    endtask

    initial begin
        logic [15:0] lf;
        @(negedge clk);
        // R1: default reload 0xFF gives the first fire on pulse 256
        do_reset();
        cyc(1, 2'd3, 8'd0, 0, "R1");
        for (int k = 0; k < 256; k++) cyc(0, 2'd0, 8'd0, 1, "R1");
        check("R1 fire on pulse 256", int'(irq), 1);
        // R9 hold, R8 enable keeps line, ack drops it
        for (int k = 0; k < 20; k++) cyc(0, 2'd0, 8'd0, 0, "R9");
        cyc(1, 2'd3, 8'd0, 0, "R8 enable keeps");
        cyc(1, 2'd2, 8'd0, 0, "R8 ack");
        // Sweep reload values in both modes
        for (int md = 0; md < 2; md++) begin
            for (int r = 0; r < 32; r++) begin
                alt_mode = md[0];
                do_reset();
                cyc(1, 2'd0, 8'(r), 0, "R2");
                cyc(1, 2'd1, 8'd0, 0, "R3");
                cyc(1, 2'd3, 8'd0, 0, "R8");
                for (int k = 0; k < r + 4; k++)
                    cyc(0, 2'd0, 8'd0, 1, md == 0 ? "R4 R5" : "R6 R7");
                cyc(1, 2'd2, 8'd0, 0, "R8");
            end
        end
        // R10: clear collides with a pulse
        alt_mode = 1'b0;
        do_reset();
        cyc(1, 2'd0, 8'd2, 0, "R2");
        cyc(1, 2'd3, 8'd0, 0, "R8");
        cyc(0, 2'd0, 8'd0, 1, "R4");
        cyc(0, 2'd0, 8'd0, 1, "R4");
        cyc(1, 2'd1, 8'd0, 1, "R10");
        for (int k = 0; k < 3; k++) cyc(0, 2'd0, 8'd0, 1, "R10");
        // R10 in alt mode: pending clear survives the colliding pulse
        alt_mode = 1'b1;
        do_reset();
        cyc(1, 2'd0, 8'd0, 0, "R2");
        cyc(1, 2'd3, 8'd0, 0, "R8");
        cyc(1, 2'd1, 8'd0, 1, "R10");
        cyc(0, 2'd0, 8'd0, 1, "R10 R7");
        cyc(1, 2'd2, 8'd0, 0, "R8");
        cyc(1, 2'd3, 8'd0, 0, "R8");
        cyc(0, 2'd0, 8'd0, 1, "R7");
        // R11: ack collides with a firing pulse; reload write collides with a reload
        alt_mode = 1'b0;
        do_reset();
        cyc(1, 2'd0, 8'd1, 0, "R2");
        cyc(1, 2'd3, 8'd0, 0, "R8");
        cyc(0, 2'd0, 8'd0, 1, "R4");
        cyc(1, 2'd2, 8'd0, 1, "R11");
        cyc(1, 2'd3, 8'd0, 0, "R8");
        cyc(1, 2'd0, 8'd5, 1, "R11");
        for (int k = 0; k < 7; k++) cyc(0, 2'd0, 8'd0, 1, "R11");
        // Pseudo-random mix in both modes
        for (int md = 0; md < 2; md++) begin
            alt_mode = md[0];
            do_reset();
            lf = 16'hACE1 ^ 16'(md);
            for (int k = 0; k < 3000; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                cyc(lf[2:1] == 2'd0, lf[4:3], {6'd0, lf[6:5]}, lf[0], "R3 R4 R5 R6 R7 R11");
            end
        end
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run incomplete, actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule